// File: doc/BRIEF.md
# Seven-Level Bus Interrupter with Acknowledge Response

This block raises an interrupt on one of seven active-low request lines on behalf of two sources: a request bit that software sets through the register port, and a level-sensitive user input. Each source has its own programmable level and enable. When an interrupt-acknowledge cycle arrives on the daisy-chain input, the block compares the acknowledged level with its enabled, pending sources. If one of them matches, it returns an 8-bit status/ID vector with a one-cycle acknowledge pulse. If none matches, it passes the acknowledge on to the next board through the daisy-chain output.

The two sources are released in different ways. The software source clears itself when it is acknowledged and records that event in an acknowledge flag. The user source latches a sticky status bit that stays set until software clears it. Software should clear it only after it has quietened the external cause. If both sources wait on the same level, the software source is answered first. Bit 0 of the returned vector tells the handler which source was answered.

Top module: `intr_iack_unit`

## Requirements
- R1: After a synchronous reset all request lines are high (released), the daisy-chain output is high, the acknowledge pulse is low, and every register reads back as 0.
- R2: The level map register (address 0) holds the user level in bits 6:4 and the software level in bits 2:0. Both fields read back. A source mapped to level L in 1..7 drives `irq_n[L-1]` low two clock edges after the write that made it active.
- R3: A level field of 0 keeps that source off every request line, even when it is pending and enabled.
- R4: The enable register (address 4) gates the request lines and the acknowledge response, with bit 0 for the software source and bit 1 for the user source. The status bits are set whether or not the source is enabled.
- R5: Writing 1 to bit 0 of the request register (address 2) makes a software request pending. Bit 0 of that register reads 1 while the request is pending.
- R6: An acknowledge cycle that answers the software source gives one `vec_ack` pulse with `vec_data` = {vector register bits 7:1, 0}. It also clears the software request and sets the acknowledge flag (status register bit 2). The vector register is at address 1 and stores bits 7:1 of the written byte.
- R7: Writing 1 to status register (address 3) bit 0 withdraws a pending software request and releases its line. Writing 1 to status bit 2 clears the acknowledge flag.
- R8: A high user input sets status bit 1, which stays set after the input falls. An acknowledge that answers the user source returns {vector bits 7:1, 1} and leaves the status set. Writing 1 to status bit 1 clears it only while the user input is low.
- R9: When both sources are pending and enabled on the same level, the first acknowledge answers the software source and the next one answers the user source.
- R10: An acknowledge that no source answers drives `ack_out_n` low one edge after `ack_in_n` falls, keeps it low while `ack_in_n` stays low, and gives no `vec_ack` pulse. `ack_out_n` returns high one edge after `ack_in_n` rises.
- R11: A source answers only when the acknowledged level on `ack_lvl` equals its programmed level. A pending source on another level does not answer and stays pending.
- R12: Two sources mapped to different levels drive both lines low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears on the next edge |
| reg_addr | input | AW (3) | Register address |
| wr_data | input | DW (8) | Register write data |
| rd_data | output | DW (8) | Registered read data |
| usr_req | input | 1 | Level-sensitive user interrupt input |
| ack_in_n | input | 1 | Daisy-chain acknowledge input, active low |
| ack_lvl | input | 3 | Level being acknowledged (address bits 3:1 of the cycle) |
| ack_out_n | output | 1 | Daisy-chain acknowledge output, active low |
| vec_ack | output | 1 | One-cycle pulse: vector is valid |
| vec_data | output | 8 | Returned status/ID vector |
| irq_n | output | 7 | Request lines, bit i is level i+1, active low |

## Verification
The software source, the user source and both together are each tried on one shared level, and then on two separate levels. These runs separate the fixed priority order from any mix-up between the two level fields. Acknowledges are issued for levels that match, levels that do not match, and pending sources that are disabled. This tells a correct answer apart from a forwarded chain, and also checks that the enable gates both the line and the response. Each release path is tried: acknowledge, write-one-to-clear with the user input high, and with it low. This shows which path clears which source and whether the sticky status re-sets.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned LVL_W   = 3;
  localparam int unsigned NUM_LVL = 7;
  localparam int unsigned VEC_W   = 8;

  localparam int unsigned ADDR_MAP  = 0;
  localparam int unsigned ADDR_VEC  = 1;
  localparam int unsigned ADDR_REQ  = 2;
  localparam int unsigned ADDR_STAT = 3;
  localparam int unsigned ADDR_EN   = 4;

  typedef struct packed {
    logic [LVL_W-1:0] usr_lvl;
    logic [LVL_W-1:0] sw_lvl;
    logic             usr_en;
    logic             sw_en;
  } intr_cfg_t;
endpackage

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             usr_req,
  input  logic             sw_ack_clr,
  output intr_cfg_t        cfg,
  output logic [VEC_W-2:0] vec_hi,
  output logic             sw_pend,
  output logic             usr_stat,
  output logic [DW-1:0]    rd_data
);
  localparam logic [AW-1:0] A_MAP  = AW'(ADDR_MAP);
  localparam logic [AW-1:0] A_VEC  = AW'(ADDR_VEC);
  localparam logic [AW-1:0] A_REQ  = AW'(ADDR_REQ);
  localparam logic [AW-1:0] A_STAT = AW'(ADDR_STAT);
  localparam logic [AW-1:0] A_EN   = AW'(ADDR_EN);

  logic ack_flag;
  logic wr_map, wr_vec, wr_req, wr_stat, wr_en_reg;
  logic [VEC_W-1:0] rd_val;

  assign wr_map    = wr_en && (reg_addr == A_MAP);
  assign wr_vec    = wr_en && (reg_addr == A_VEC);
  assign wr_req    = wr_en && (reg_addr == A_REQ);
  assign wr_stat   = wr_en && (reg_addr == A_STAT);
  assign wr_en_reg = wr_en && (reg_addr == A_EN);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      vec_hi   <= '0;
      sw_pend  <= 1'b0;
      usr_stat <= 1'b0;
      ack_flag <= 1'b0;
    end else begin
      if (wr_map) begin
        cfg.usr_lvl <= wr_data[6:4];
        cfg.sw_lvl  <= wr_data[2:0];
      end
      if (wr_en_reg) begin
        cfg.sw_en  <= wr_data[0];
        cfg.usr_en <= wr_data[1];
      end
      if (wr_vec) vec_hi <= wr_data[VEC_W-1:1];
      // software source: set by request write, released by ack or W1C
      if (wr_req && wr_data[0])                      sw_pend <= 1'b1;
      else if (sw_ack_clr || (wr_stat && wr_data[0])) sw_pend <= 1'b0;
      // acknowledge flag
      if (sw_ack_clr)                    ack_flag <= 1'b1;
      else if (wr_stat && wr_data[2])    ack_flag <= 1'b0;
      // user source: input re-sets over a clear
      if (usr_req)                       usr_stat <= 1'b1;
      else if (wr_stat && wr_data[1])    usr_stat <= 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      A_MAP:  rd_val = {1'b0, cfg.usr_lvl, 1'b0, cfg.sw_lvl};
      A_VEC:  rd_val = {vec_hi, 1'b0};
      A_REQ:  rd_val = {7'b0, sw_pend};
      A_STAT: rd_val = {5'b0, ack_flag, usr_stat, sw_pend};
      A_EN:   rd_val = {6'b0, cfg.usr_en, cfg.sw_en};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= DW'(rd_val);
  end
endmodule

// File: rtl/intr_line_drv.sv
module intr_line_drv
  import intr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  intr_cfg_t          cfg,
  input  logic               sw_pend,
  input  logic               usr_stat,
  output logic [NUM_LVL-1:0] irq_n
);
  logic sw_live, usr_live;
  assign sw_live  = cfg.sw_en  && sw_pend;
  assign usr_live = cfg.usr_en && usr_stat;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_line
    localparam logic [LVL_W-1:0] LV = LVL_W'(g + 1);
    logic hit;
    assign hit = (sw_live && (cfg.sw_lvl == LV)) || (usr_live && (cfg.usr_lvl == LV));
    always_ff @(posedge clk) begin
      if (rst) irq_n[g] <= 1'b1;
      else     irq_n[g] <= ~hit;
    end
  end
endmodule

// File: rtl/intr_ack_resp.sv
module intr_ack_resp
  import intr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_in_n,
  input  logic [LVL_W-1:0] ack_lvl,
  input  intr_cfg_t        cfg,
  input  logic             sw_pend,
  input  logic             usr_stat,
  input  logic [VEC_W-2:0] vec_hi,
  output logic             sw_ack_clr,
  output logic             ack_out_n,
  output logic             vec_ack,
  output logic [VEC_W-1:0] vec_data
);
  logic ack_in_d;
  logic start, sw_hit, usr_hit;

  assign start   = ack_in_d && !ack_in_n;
  assign sw_hit  = cfg.sw_en && sw_pend && (cfg.sw_lvl != '0) && (cfg.sw_lvl == ack_lvl);
  assign usr_hit = cfg.usr_en && usr_stat && (cfg.usr_lvl != '0) && (cfg.usr_lvl == ack_lvl);
  assign sw_ack_clr = start && sw_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_in_d  <= 1'b1;
      ack_out_n <= 1'b1;
      vec_ack   <= 1'b0;
      vec_data  <= '0;
    end else begin
      ack_in_d <= ack_in_n;
      vec_ack  <= start && (sw_hit || usr_hit);
      if (start && sw_hit)       vec_data <= {vec_hi, 1'b0};
      else if (start && usr_hit) vec_data <= {vec_hi, 1'b1};
      if (ack_in_n)                          ack_out_n <= 1'b1;
      else if (start && !sw_hit && !usr_hit) ack_out_n <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_iack_unit.sv
module intr_iack_unit
  import intr_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic               usr_req,
  input  logic               ack_in_n,
  input  logic [LVL_W-1:0]   ack_lvl,
  output logic               ack_out_n,
  output logic               vec_ack,
  output logic [VEC_W-1:0]   vec_data,
  output logic [NUM_LVL-1:0] irq_n
);
  intr_cfg_t        cfg;
  logic [VEC_W-2:0] vec_hi;
  logic             sw_pend, usr_stat, sw_ack_clr;

  intr_regs #(.AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .usr_req(usr_req), .sw_ack_clr(sw_ack_clr), .cfg(cfg),
    .vec_hi(vec_hi), .sw_pend(sw_pend), .usr_stat(usr_stat), .rd_data(rd_data)
  );

  intr_line_drv lines_i (
    .clk(clk), .rst(rst), .cfg(cfg), .sw_pend(sw_pend), .usr_stat(usr_stat),
    .irq_n(irq_n)
  );

  intr_ack_resp resp_i (
    .clk(clk), .rst(rst), .ack_in_n(ack_in_n), .ack_lvl(ack_lvl), .cfg(cfg),
    .sw_pend(sw_pend), .usr_stat(usr_stat), .vec_hi(vec_hi),
    .sw_ack_clr(sw_ack_clr), .ack_out_n(ack_out_n), .vec_ack(vec_ack),
    .vec_data(vec_data)
  );
endmodule

// File: rtl/intr_iack_unit_chk.sv
module intr_iack_unit_chk
  import intr_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               ack_in_n,
  input logic               ack_out_n,
  input logic               vec_ack,
  input logic [NUM_LVL-1:0] irq_n
);
  p_irq_released_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&irq_n && ack_out_n && !vec_ack));

  p_ack_single_r6: assert property (@(posedge clk) disable iff (rst)
    vec_ack |=> !vec_ack);

  p_ack_needs_chain_r6: assert property (@(posedge clk) disable iff (rst)
    vec_ack |-> !$past(ack_in_n));

  p_ack_or_pass_r10: assert property (@(posedge clk) disable iff (rst)
    vec_ack |-> ack_out_n);

  p_chain_release_r10: assert property (@(posedge clk) disable iff (rst)
    ack_in_n |=> ack_out_n);

  p_chain_from_input_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_out_n) |-> !$past(ack_in_n));
endmodule

bind intr_iack_unit intr_iack_unit_chk chk_i (
  .clk(clk), .rst(rst), .ack_in_n(ack_in_n), .ack_out_n(ack_out_n),
  .vec_ack(vec_ack), .irq_n(irq_n)
);

// File: tb/intr_iack_unit_tb_top.sv
module intr_iack_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       usr_req = 1'b0;
  logic       ack_in_n = 1'b1;
  logic [2:0] ack_lvl = '0;
  logic       ack_out_n, vec_ack;
  logic [7:0] vec_data;
  logic [6:0] irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_iack_unit dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .usr_req(usr_req), .ack_in_n(ack_in_n),
    .ack_lvl(ack_lvl), .ack_out_n(ack_out_n), .vec_ack(vec_ack),
    .vec_data(vec_data), .irq_n(irq_n)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; reg_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  // one acknowledge cycle: returns pulse, vector, chain state, pulse on 2nd cycle
  task automatic iack(input logic [2:0] lvl, output logic got, output logic [7:0] v,
                      output logic chained, output logic got2, output logic rel);
    @(negedge clk); ack_lvl = lvl; ack_in_n = 1'b0;
    @(negedge clk); got = vec_ack; v = vec_data; chained = !ack_out_n;
    @(negedge clk); got2 = vec_ack; ack_in_n = 1'b1;
    @(negedge clk); rel = ack_out_n;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1", "irq_n", irq_n, 7'h7F);
    check("R1", "ack_out_n", ack_out_n, 1);
    check("R1", "vec_ack", vec_ack, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      check("R1", "register readback", d, 0);
    end
  endtask

  task automatic t_sw_basic;
    logic [7:0] d, v; logic g, c, g2, r;
    wr(0, 8'h04); wr(1, 8'hA5); wr(4, 8'h01); wr(2, 8'h01);
    cyc(1);
    check("R2", "sw level 4 line", irq_n, 7'h77);
    rd(0, d); check("R2", "map readback", d, 8'h04);
    rd(1, d); check("R6", "vector readback", d, 8'hA4);
    rd(2, d); check("R5", "request pending", d, 8'h01);
    iack(3'd4, g, v, c, g2, r);
    check("R6", "ack pulse", g, 1);
    check("R6", "sw vector", v, 8'hA4);
    check("R6", "no chain", c, 0);
    check("R6", "pulse one cycle", g2, 0);
    check("R6", "line released", irq_n, 7'h7F);
    rd(3, d); check("R6", "status after ack", d, 8'h04);
    wr(3, 8'h04);
    rd(3, d); check("R7", "ack flag cleared", d, 8'h00);
  endtask

  task automatic t_enable;
    logic [7:0] d, v; logic g, c, g2, r;
    wr(4, 8'h00); wr(2, 8'h01); cyc(1);
    check("R4", "disabled no line", irq_n, 7'h7F);
    rd(3, d); check("R4", "status set while disabled", d, 8'h01);
    iack(3'd4, g, v, c, g2, r);
    check("R4", "disabled no answer", g, 0);
    check("R10", "disabled forwarded", c, 1);
    check("R10", "chain released", r, 1);
    wr(4, 8'h01); cyc(1);
    check("R4", "enabled line", irq_n, 7'h77);
    wr(3, 8'h01); cyc(1);
    check("R7", "withdrawn line", irq_n, 7'h7F);
    rd(2, d); check("R7", "request cleared", d, 8'h00);
  endtask

  task automatic t_level0;
    logic [7:0] d;
    wr(0, 8'h00); wr(4, 8'h03); wr(2, 8'h01); cyc(2);
    check("R3", "level 0 no line", irq_n, 7'h7F);
    rd(2, d); check("R3", "still pending", d, 8'h01);
    wr(3, 8'h01);
  endtask

  task automatic t_user;
    logic [7:0] d, v; logic g, c, g2, r;
    wr(0, 8'h20); wr(4, 8'h02);
    @(negedge clk); usr_req = 1'b1;
    cyc(2);
    check("R8", "user level 2 line", irq_n, 7'h7D);
    usr_req = 1'b0; cyc(2);
    check("R8", "sticky line", irq_n, 7'h7D);
    rd(3, d); check("R8", "sticky status", d, 8'h02);
    iack(3'd2, g, v, c, g2, r);
    check("R8", "user ack", g, 1);
    check("R8", "user vector", v, 8'hA5);
    check("R8", "not cleared by ack", irq_n, 7'h7D);
    usr_req = 1'b1;
    wr(3, 8'h02);
    rd(3, d); check("R8", "re-set while input high", d, 8'h02);
    usr_req = 1'b0;
    wr(3, 8'h02); cyc(1);
    rd(3, d); check("R8", "cleared while input low", d, 8'h00);
    check("R8", "line released", irq_n, 7'h7F);
  endtask

  task automatic t_priority;
    logic [7:0] v; logic g, c, g2, r;
    wr(0, 8'h33); wr(4, 8'h03); wr(2, 8'h01);
    @(negedge clk); usr_req = 1'b1;
    cyc(2);
    check("R9", "shared line", irq_n, 7'h7B);
    iack(3'd3, g, v, c, g2, r);
    check("R9", "first answer sw", v, 8'hA4);
    iack(3'd3, g, v, c, g2, r);
    check("R9", "second answer ack", g, 1);
    check("R9", "second answer user", v, 8'hA5);
    usr_req = 1'b0;
    wr(3, 8'h06);
  endtask

  task automatic t_mismatch;
    logic [7:0] d, v; logic g, c, g2, r;
    wr(0, 8'h05); wr(4, 8'h01); wr(2, 8'h01);
    iack(3'd6, g, v, c, g2, r);
    check("R11", "no answer wrong level", g, 0);
    check("R10", "forwarded low", c, 1);
    check("R10", "released high", r, 1);
    rd(2, d); check("R11", "still pending", d, 8'h01);
    wr(3, 8'h01);
  endtask

  task automatic t_two_lines;
    logic [7:0] d;
    wr(0, 8'h71); wr(4, 8'h03); wr(2, 8'h01);
    @(negedge clk); usr_req = 1'b1;
    cyc(2);
    check("R12", "two lines", irq_n, 7'h3E);
    rd(0, d); check("R2", "map fields", d, 8'h71);
    usr_req = 1'b0;
    wr(3, 8'h03);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_sw_basic();
    t_enable();
    t_level0();
    t_user();
    t_priority();
    t_mismatch();
    t_two_lines();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule